// File: doc/BRIEF.md
# Dual-Port Pin-Change Interrupt Controller

This block generates the interrupt outputs for two GPIO ports, A and B, each `PORT_W` bits wide. Raw pin levels pass through a synchronizer first. Each enabled input pin is then compared in one of two ways: against its own value from the previous clock, or against a per-pin default bit. The first qualifying event on a port does two things: it stores the port's synchronized pin values in a capture register and it raises that port's interrupt flag. The flag stays set until a read of the selected register completes.

The surrounding register interface has two jobs. It holds the configuration fields, and it pulses a read-done strobe when the last bit of a pin-value or capture-register read has left the device. Each of the two interrupt outputs can follow only its own port's flag, or both outputs can carry the OR of the two flags. Three drive styles are available: active-low push-pull, active-high push-pull, and open-drain. In open-drain style the block presents a pull-low enable.

Top module: `gpio_ioc_ctrl`

## Requirements
- R1: A pin whose interrupt-enable bit is 0 never sets its port's flag.
- R2: A compare-select bit of 0 flags a difference between the pin's synchronized value and its value one clock earlier. A compare-select bit of 1 flags a difference between the pin's synchronized value and its default bit.
- R3: Only pins whose direction bit is 1 (input) can set a flag. Pins with direction 0 (output) are ignored.
- R4: The first qualifying event copies the synchronized port value into the capture output and sets the flag. A pin edge at the inputs shows on the flag after three rising clock edges.
- R5: While a port's flag is set, further events on that port leave both the capture value and the flag unchanged.
- R6: With clear-select 0, a read-done pulse for the port's pin-value register clears its flag. With clear-select 1, a read-done pulse for the capture register clears it. The other strobe has no effect. The flag is low after the clock edge that samples the pulse.
- R7: The ports are independent. An event or a clear on one port leaves the other port's flag and capture unchanged.
- R8: With mirror at 0, each output follows its own port's flag. With mirror at 1, both outputs show the OR of the two flags, and each flag is still cleared only by its own port's strobe.
- R9: Drive mode 0 is active-low push-pull, with enable held at 1. Mode 1 is active-high push-pull, with enable held at 1. Modes 2 and 3 are open-drain: the output is held at 0 and the pull-low enable is 1 only while the interrupt is active.
- R10: If a default-compare mismatch still exists when a flag is cleared, the flag sets again on the next clock edge and the capture is overwritten with the current port value.
- R11: Reset clears both flags, the capture registers and the synchronizer. The outputs then sit at their inactive level for the selected mode.
- R12: The previous-value reference updates every clock. A pin that moves to a new level and stays there produces one event and no later re-trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_a_i | input | PORT_W | Raw port A pin levels |
| pins_b_i | input | PORT_W | Raw port B pin levels |
| dir_a_i | input | PORT_W | Port A direction, 1 = input |
| dir_b_i | input | PORT_W | Port B direction, 1 = input |
| ien_a_i | input | PORT_W | Port A per-pin interrupt enable |
| ien_b_i | input | PORT_W | Port B per-pin interrupt enable |
| csel_a_i | input | PORT_W | Port A compare select, 1 = against default |
| csel_b_i | input | PORT_W | Port B compare select, 1 = against default |
| dflt_a_i | input | PORT_W | Port A default compare values |
| dflt_b_i | input | PORT_W | Port B default compare values |
| mirror_i | input | 1 | 1 = both outputs carry OR of flags |
| clr_sel_i | input | 1 | 0 = pin-value read clears, 1 = capture read clears |
| drv_mode_i | input | 2 | Output drive style |
| rd_pin_a_done_i | input | 1 | Port A pin-value read completed |
| rd_cap_a_done_i | input | 1 | Port A capture read completed |
| rd_pin_b_done_i | input | 1 | Port B pin-value read completed |
| rd_cap_b_done_i | input | 1 | Port B capture read completed |
| pinval_a_o | output | PORT_W | Port A synchronized pin values |
| pinval_b_o | output | PORT_W | Port B synchronized pin values |
| cap_a_o | output | PORT_W | Port A capture register |
| cap_b_o | output | PORT_W | Port B capture register |
| int_a_o | output | 1 | Interrupt output A level |
| int_b_o | output | 1 | Interrupt output B level |
| int_a_oe_o | output | 1 | Output A drive / pull-low enable |
| int_b_oe_o | output | 1 | Output B drive / pull-low enable |

## Verification
A pin edge driven at a falling clock edge passes through two synchronizer flops and then the flag register. The flag and the capture value are therefore due after the third rising edge, and the bench samples them at the falling edge that follows. A read-done pulse clears the flag at the next rising edge. A standing default mismatch re-sets the flag one edge after that, so the bench samples both the gap and the re-set on consecutive falling edges. Output level and enable are combinational from the flags and the mode. They are checked one falling edge after a mode or mirror change.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;

   typedef enum logic [1:0] {
      DRV_ACT_LOW  = 2'd0,
      DRV_ACT_HIGH = 2'd1,
      DRV_OD       = 2'd2,
      DRV_OD_ALT   = 2'd3
   } drv_mode_e;

   localparam int unsigned NUM_PORTS = 2;

   function automatic logic drive_is_od(input drv_mode_e m);
      return (m == DRV_OD) || (m == DRV_OD_ALT);
   endfunction

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   localparam int unsigned LAST = STAGES - 1;

   logic [W-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ioc_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[LAST];
endmodule

// File: rtl/ioc_port_unit.sv
module ioc_port_unit #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins_s_i,
   input  logic [W-1:0] dir_i,
   input  logic [W-1:0] ien_i,
   input  logic [W-1:0] csel_i,
   input  logic [W-1:0] dflt_i,
   input  logic         clr_sel_i,
   input  logic         rd_pin_done_i,
   input  logic         rd_cap_done_i,
   output logic         flag_o,
   output logic [W-1:0] cap_o
);
   logic [W-1:0] prev_q;
   logic [W-1:0] mism;
   logic         evt;
   logic         clr;
   logic         flag_q;
   logic [W-1:0] cap_q;

   generate
      if (W < 1) begin : g_bad_width
         $error("ioc_port_unit: W must be positive");
      end
      for (genvar b = 0; b < W; b++) begin : g_bit
         logic ref_bit;
         assign ref_bit = csel_i[b] ? dflt_i[b] : prev_q[b];
         assign mism[b] = dir_i[b] & ien_i[b] & (pins_s_i[b] ^ ref_bit);
      end
   endgenerate

   assign evt = |mism;
   assign clr = clr_sel_i ? rd_cap_done_i : rd_pin_done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins_s_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         cap_q  <= '0;
      end else if (flag_q) begin
         if (clr) flag_q <= 1'b0;
      end else if (evt) begin
         flag_q <= 1'b1;
         cap_q  <= pins_s_i;
      end
   end

   assign flag_o = flag_q;
   assign cap_o  = cap_q;
endmodule

// File: rtl/ioc_out_drv.sv
module ioc_out_drv
   import gpio_ioc_pkg::*;
(
   input  logic       own_flag_i,
   input  logic       peer_flag_i,
   input  logic       mirror_i,
   input  logic [1:0] mode_i,
   output logic       pad_o,
   output logic       pad_oe_o
);
   logic      active;
   drv_mode_e mode;

   assign mode   = drv_mode_e'(mode_i);
   assign active = own_flag_i | (mirror_i & peer_flag_i);

   always_comb begin
      pad_o    = 1'b0;
      pad_oe_o = 1'b1;
      if (drive_is_od(mode)) begin
         pad_o    = 1'b0;
         pad_oe_o = active;
      end else if (mode == DRV_ACT_HIGH) begin
         pad_o = active;
      end else begin
         pad_o = ~active;
      end
   end
endmodule

// File: rtl/gpio_ioc_ctrl.sv
module gpio_ioc_ctrl
   import gpio_ioc_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] pins_a_i,
   input  logic [PORT_W-1:0] pins_b_i,
   input  logic [PORT_W-1:0] dir_a_i,
   input  logic [PORT_W-1:0] dir_b_i,
   input  logic [PORT_W-1:0] ien_a_i,
   input  logic [PORT_W-1:0] ien_b_i,
   input  logic [PORT_W-1:0] csel_a_i,
   input  logic [PORT_W-1:0] csel_b_i,
   input  logic [PORT_W-1:0] dflt_a_i,
   input  logic [PORT_W-1:0] dflt_b_i,
   input  logic              mirror_i,
   input  logic              clr_sel_i,
   input  logic [1:0]        drv_mode_i,
   input  logic              rd_pin_a_done_i,
   input  logic              rd_cap_a_done_i,
   input  logic              rd_pin_b_done_i,
   input  logic              rd_cap_b_done_i,
   output logic [PORT_W-1:0] pinval_a_o,
   output logic [PORT_W-1:0] pinval_b_o,
   output logic [PORT_W-1:0] cap_a_o,
   output logic [PORT_W-1:0] cap_b_o,
   output logic              int_a_o,
   output logic              int_b_o,
   output logic              int_a_oe_o,
   output logic              int_b_oe_o
);
   localparam int unsigned NP = NUM_PORTS;

   logic [PORT_W-1:0] raw_v  [NP];
   logic [PORT_W-1:0] sync_v [NP];
   logic [PORT_W-1:0] dir_v  [NP];
   logic [PORT_W-1:0] ien_v  [NP];
   logic [PORT_W-1:0] csel_v [NP];
   logic [PORT_W-1:0] dflt_v [NP];
   logic [PORT_W-1:0] cap_v  [NP];
   logic [NP-1:0]     rdp_v;
   logic [NP-1:0]     rdc_v;
   logic [NP-1:0]     flag_v;
   logic [NP-1:0]     pad_v;
   logic [NP-1:0]     oe_v;
   logic              flag_a;
   logic              flag_b;

   assign raw_v[0]  = pins_a_i;
   assign raw_v[1]  = pins_b_i;
   assign dir_v[0]  = dir_a_i;
   assign dir_v[1]  = dir_b_i;
   assign ien_v[0]  = ien_a_i;
   assign ien_v[1]  = ien_b_i;
   assign csel_v[0] = csel_a_i;
   assign csel_v[1] = csel_b_i;
   assign dflt_v[0] = dflt_a_i;
   assign dflt_v[1] = dflt_b_i;
   assign rdp_v     = {rd_pin_b_done_i, rd_pin_a_done_i};
   assign rdc_v     = {rd_cap_b_done_i, rd_cap_a_done_i};

   generate
      if (PORT_W < 1 || PORT_W > 64) begin : g_bad_width
         $error("gpio_ioc_ctrl: PORT_W out of range");
      end
      if (NP != 2) begin : g_bad_ports
         $error("gpio_ioc_ctrl: exactly two ports supported");
      end
      for (genvar p = 0; p < NP; p++) begin : g_port
         ioc_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw_v[p]),
            .q_o   (sync_v[p])
         );
         ioc_port_unit #(.W(PORT_W)) u_unit (
            .clk           (clk),
            .rst_n         (rst_n),
            .pins_s_i      (sync_v[p]),
            .dir_i         (dir_v[p]),
            .ien_i         (ien_v[p]),
            .csel_i        (csel_v[p]),
            .dflt_i        (dflt_v[p]),
            .clr_sel_i     (clr_sel_i),
            .rd_pin_done_i (rdp_v[p]),
            .rd_cap_done_i (rdc_v[p]),
            .flag_o        (flag_v[p]),
            .cap_o         (cap_v[p])
         );
         ioc_out_drv u_drv (
            .own_flag_i  (flag_v[p]),
            .peer_flag_i (flag_v[NP-1-p]),
            .mirror_i    (mirror_i),
            .mode_i      (drv_mode_i),
            .pad_o       (pad_v[p]),
            .pad_oe_o    (oe_v[p])
         );
      end
   endgenerate

   assign flag_a     = flag_v[0];
   assign flag_b     = flag_v[1];
   assign pinval_a_o = sync_v[0];
   assign pinval_b_o = sync_v[1];
   assign cap_a_o    = cap_v[0];
   assign cap_b_o    = cap_v[1];
   assign int_a_o    = pad_v[0];
   assign int_b_o    = pad_v[1];
   assign int_a_oe_o = oe_v[0];
   assign int_b_oe_o = oe_v[1];
endmodule

// File: rtl/gpio_ioc_chk.sv
module gpio_ioc_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] ien_a_i,
   input logic [W-1:0] dir_a_i,
   input logic         clr_sel_i,
   input logic         rd_pin_a_done_i,
   input logic         rd_cap_a_done_i,
   input logic         mirror_i,
   input logic [1:0]   drv_mode_i,
   input logic         int_a_o,
   input logic         int_b_o,
   input logic         int_a_oe_o,
   input logic         int_b_oe_o,
   input logic [W-1:0] cap_a_o,
   input logic [W-1:0] pinval_a_o,
   input logic         flag_a
);
   logic clr_a;
   assign clr_a = clr_sel_i ? rd_cap_a_done_i : rd_pin_a_done_i;

   assert_no_recapture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_a && !clr_a) |=> ($stable(cap_a_o) && flag_a));

   assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_a && clr_a) |=> !flag_a);

   assert_inputs_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_a && ((ien_a_i & dir_a_i) == '0)) |=> !flag_a);

   assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_a) |-> (cap_a_o == $past(pinval_a_o)));

   assert_od_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      drv_mode_i[1] |-> (!int_a_o && !int_b_o));

   assert_mirror_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mirror_i |-> ((int_a_o == int_b_o) && (int_a_oe_o == int_b_oe_o)));
endmodule

bind gpio_ioc_ctrl gpio_ioc_chk #(.W(PORT_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ien_a_i         (ien_a_i),
   .dir_a_i         (dir_a_i),
   .clr_sel_i       (clr_sel_i),
   .rd_pin_a_done_i (rd_pin_a_done_i),
   .rd_cap_a_done_i (rd_cap_a_done_i),
   .mirror_i        (mirror_i),
   .drv_mode_i      (drv_mode_i),
   .int_a_o         (int_a_o),
   .int_b_o         (int_b_o),
   .int_a_oe_o      (int_a_oe_o),
   .int_b_oe_o      (int_b_oe_o),
   .cap_a_o         (cap_a_o),
   .pinval_a_o      (pinval_a_o),
   .flag_a          (flag_a)
);

// File: tb/gpio_ioc_ctrl_test.sv
`timescale 1ns/1ps
module gpio_ioc_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pins_a_i = '0, pins_b_i = '0;
   logic [7:0] dir_a_i = '0, dir_b_i = '0;
   logic [7:0] ien_a_i = '0, ien_b_i = '0;
   logic [7:0] csel_a_i = '0, csel_b_i = '0;
   logic [7:0] dflt_a_i = '0, dflt_b_i = '0;
   logic       mirror_i = 1'b0, clr_sel_i = 1'b0;
   logic [1:0] drv_mode_i = 2'd0;
   logic       rd_pin_a_done_i = 1'b0, rd_cap_a_done_i = 1'b0;
   logic       rd_pin_b_done_i = 1'b0, rd_cap_b_done_i = 1'b0;
   logic [7:0] pinval_a_o, pinval_b_o, cap_a_o, cap_b_o;
   logic       int_a_o, int_b_o, int_a_oe_o, int_b_oe_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   gpio_ioc_ctrl #(.PORT_W(8), .SYNC_STAGES(2)) uut (.*);

   // {dir, ien, csel, dflt, base, new, expect_int}
   localparam int NV = 8;
   localparam logic [48:0] VEC [NV] = '{
      {8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 1'b1},  // R1 R2 change on enabled pin
      {8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0},  // R1 disabled pin
      {8'hFE, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0},  // R3 output pin
      {8'hFF, 8'hF0, 8'hF0, 8'hA0, 8'hA0, 8'h80, 1'b1},  // R2 default mismatch
      {8'hFF, 8'hF0, 8'hF0, 8'hA0, 8'hA0, 8'hA0, 1'b0},  // R2 default match
      {8'hFF, 8'hFF, 8'hF0, 8'h00, 8'h00, 8'h0F, 1'b1},  // R2 mixed sources
      {8'hFF, 8'h80, 8'h00, 8'h00, 8'h80, 8'h00, 1'b1},  // R2 falling edge
      {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b0}   // R1 none enabled
   };

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      ien_a_i = '0;
      ien_b_i = '0;
      tick(4);
      rd_pin_a_done_i = 1'b1; rd_cap_a_done_i = 1'b1;
      rd_pin_b_done_i = 1'b1; rd_cap_b_done_i = 1'b1;
      tick(1);
      rd_pin_a_done_i = 1'b0; rd_cap_a_done_i = 1'b0;
      rd_pin_b_done_i = 1'b0; rd_cap_b_done_i = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      tick(3);
      // R11 reset state, active-low mode
      check("R11 int_a level", {7'd0, int_a_o}, 8'h01);
      check("R11 int_b level", {7'd0, int_b_o}, 8'h01);
      check("R11 cap_a", cap_a_o, 8'h00);
      check("R11 cap_b", cap_b_o, 8'h00);
      rst_n = 1'b1;
      drv_mode_i = 2'd1;
      tick(2);

      for (int i = 0; i < NV; i++) begin
         logic [7:0] vdir, vien, vcsel, vdflt, vbase, vnew;
         logic       vexp;
         {vdir, vien, vcsel, vdflt, vbase, vnew, vexp} = VEC[i];
         pins_a_i = vbase;
         clear_all();
         dir_a_i = vdir; csel_a_i = vcsel; dflt_a_i = vdflt; ien_a_i = vien;
         tick(4);
         check("R1 R2 R3 quiet before stimulus", {7'd0, int_a_o}, 8'h00);
         pins_a_i = vnew;
         tick(3);
         check("R1 R2 R3 vector int", {7'd0, int_a_o}, {7'd0, vexp});
         if (vexp) check("R4 vector capture", cap_a_o, vnew);
      end

      // R5 and R12
      pins_a_i = 8'h00;
      clear_all();
      dir_a_i = 8'hFF; csel_a_i = 8'h00; ien_a_i = 8'hFF;
      tick(4);
      pins_a_i = 8'h01;
      tick(3);
      check("R4 flag set", {7'd0, int_a_o}, 8'h01);
      check("R4 capture", cap_a_o, 8'h01);
      pins_a_i = 8'h03;
      tick(4);
      check("R5 flag held", {7'd0, int_a_o}, 8'h01);
      check("R5 no recapture", cap_a_o, 8'h01);
      rd_pin_a_done_i = 1'b1; tick(1); rd_pin_a_done_i = 1'b0;
      check("R6 pin read clears", {7'd0, int_a_o}, 8'h00);
      tick(4);
      check("R12 steady level no retrigger", {7'd0, int_a_o}, 8'h00);

      // R6 capture-read select
      clr_sel_i = 1'b1;
      pins_a_i = 8'h07;
      tick(3);
      check("R6 flag set", {7'd0, int_a_o}, 8'h01);
      rd_pin_a_done_i = 1'b1; tick(1); rd_pin_a_done_i = 1'b0;
      check("R6 pin read ignored", {7'd0, int_a_o}, 8'h01);
      rd_cap_a_done_i = 1'b1; tick(1); rd_cap_a_done_i = 1'b0;
      check("R6 capture read clears", {7'd0, int_a_o}, 8'h00);
      clr_sel_i = 1'b0;

      // R10 re-assert on pending default mismatch
      clear_all();
      csel_a_i = 8'h01; dflt_a_i = 8'h00; ien_a_i = 8'h01;
      tick(1);
      check("R10 default flag", {7'd0, int_a_o}, 8'h01);
      check("R10 first capture", cap_a_o, 8'h07);
      pins_a_i = 8'h0F;
      tick(3);
      check("R5 capture kept", cap_a_o, 8'h07);
      rd_pin_a_done_i = 1'b1; tick(1); rd_pin_a_done_i = 1'b0;
      check("R10 cleared cycle", {7'd0, int_a_o}, 8'h00);
      tick(1);
      check("R10 re-asserted", {7'd0, int_a_o}, 8'h01);
      check("R10 recaptured", cap_a_o, 8'h0F);

      // R8 mirror
      check("R8 unmirrored B", {7'd0, int_b_o}, 8'h00);
      mirror_i = 1'b1;
      tick(1);
      check("R8 mirrored B", {7'd0, int_b_o}, 8'h01);
      rd_pin_b_done_i = 1'b1; tick(1); rd_pin_b_done_i = 1'b0;
      check("R8 B read leaves A", {7'd0, int_b_o}, 8'h01);
      ien_a_i = 8'h00;
      rd_pin_a_done_i = 1'b1; tick(1); rd_pin_a_done_i = 1'b0;
      check("R8 A read clears both", {6'd0, int_a_o, int_b_o}, 8'h00);
      mirror_i = 1'b0;

      // R9 drive modes with A active, B idle
      ien_a_i = 8'h01;
      tick(1);
      drv_mode_i = 2'd0; tick(1);
      check("R9 active-low", {6'd0, int_a_o, int_a_oe_o}, 8'h01);
      drv_mode_i = 2'd2; tick(1);
      check("R9 open-drain active", {6'd0, int_a_o, int_a_oe_o}, 8'h01);
      check("R9 open-drain idle", {6'd0, int_b_o, int_b_oe_o}, 8'h00);
      drv_mode_i = 2'd3; tick(1);
      check("R9 mode 3 open-drain", {6'd0, int_a_o, int_a_oe_o}, 8'h01);
      drv_mode_i = 2'd1; tick(1);
      check("R9 active-high", {6'd0, int_a_o, int_a_oe_o}, 8'h03);

      // R7 port B on its own
      clear_all();
      dir_b_i = 8'hFF; ien_b_i = 8'h80; csel_b_i = 8'h00;
      tick(2);
      pins_b_i = 8'h80;
      tick(3);
      check("R7 port B flag", {7'd0, int_b_o}, 8'h01);
      check("R7 port B capture", cap_b_o, 8'h80);
      check("R7 port A untouched", {7'd0, int_a_o}, 8'h00);
      check("R7 port A capture kept", cap_a_o, 8'h0F);

      // R11 reset mid-run
      rst_n = 1'b0;
      tick(1);
      check("R11 flag cleared", {7'd0, int_b_o}, 8'h00);
      check("R11 capture cleared", cap_b_o, 8'h00);
      rst_n = 1'b1;
      tick(1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule